// File: doc/BRIEF.md
# Performance-to-Gear Setpoint Controller

This block turns a demanded throughput into two operating settings for a core whose instructions-per-cycle can be varied: a clock-rate setpoint and a gear fraction. The gear fraction places the core's IPC on a straight line between a lowest and a highest value. The block keeps power down with a two-regime policy. First it runs the core at its lowest IPC and raises only the clock. When the clock reaches its ceiling, the clock is held there and the gear is raised until the demand is met. Demand beyond the reachable peak saturates both settings and raises a flag.

A controller presents the demand together with the core's IPC bounds and clock ceiling, then pulses a request. The block captures these values and selects the regime. It forms one quotient with a shared radix-2 restoring divider and rounds that quotient upward, so that the delivered throughput is never below the demand. It then writes both settings in the same cycle as a one-cycle completion pulse. The settings hold until the next accepted request completes. A busy output is high while a computation runs, and any request made during that time is dropped.

Top module: `gear_setpoint_ctrl`

## Requirements
- R1: After reset, clk_set, gear, sat, busy and done are all 0.
- R2: IPC bounds are unsigned with 4 fraction bits (16 means 1.0 instruction per cycle), with ipc_lo >= 1 and ipc_hi >= ipc_lo. When perf_req*16 < ipc_lo*clk_max, the result has gear = 0, sat = 0 and clk_set = ceil(perf_req*16 / ipc_lo), so that clk_set*ipc_lo >= perf_req*16.
- R3: When perf_req*16 equals ipc_lo*clk_max exactly, the result stays in the clock-only regime: gear = 0 and clk_set = clk_max.
- R4: When ipc_lo*clk_max < perf_req*16 <= ipc_hi*clk_max, the result has clk_set = clk_max, sat = 0 and gear = ceil((perf_req*16 - ipc_lo*clk_max)*65536 / ((ipc_hi - ipc_lo)*clk_max)). Gear is an unsigned Q0.16 fraction.
- R5: If the R4 formula reaches 65536, gear is clamped to 0xFFFF, and 0xFFFF stands for full gear. At perf_req*16 = ipc_hi*clk_max, sat therefore stays 0.
- R6: When perf_req*16 > ipc_hi*clk_max, the result has sat = 1, gear = 0xFFFF and clk_set = clk_max. This also covers ipc_hi = ipc_lo with demand above the floor.
- R7: The edge that accepts a request is edge 0. done is high for exactly one cycle after edge 1 on a saturating request, and after edge 55 on every other request. New settings appear together with done.
- R8: busy is high from the edge after an accepted request until done is raised. A request made while busy is high is ignored: it produces no second result and no second done pulse.
- R9: clk_set, gear and sat change only in a cycle where done is high. Changing the demand or bound inputs without a request leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted only while busy is low |
| perf_req | input | 32 | Demanded throughput, instructions per time unit |
| ipc_lo | input | 8 | Lowest IPC, 4 fraction bits |
| ipc_hi | input | 8 | Highest IPC, 4 fraction bits |
| clk_max | input | 24 | Clock ceiling, cycles per time unit |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| clk_set | output | 24 | Clock setpoint, same units as clk_max |
| gear | output | 16 | Gear fraction, Q0.16 |
| sat | output | 1 | Demand exceeds reachable peak |

## Verification
Two of the block's functions can fall in the same cycle. In that cycle the divider hands over its result, so the settings are written and done is raised, while a fresh request arrives and must be refused. The bench provokes this by raising req with a first demand and holding it high through the whole busy window, including the finishing edge. It lowers req only once done is seen. It then judges that the settings match the first demand alone, that done does not come back on the next cycle, and that busy has fallen.

// File: rtl/gear_pkg.sv
package gear_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_DIVIDE = 2'd2
  } ctrl_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gear_classify.sv
// Scales the demand, forms the floor and peak throughputs and picks the regime.
module gear_classify #(
  parameter int MW  = 32,
  parameter int IW  = 8,
  parameter int CW  = 24,
  parameter int QF  = 4,
  parameter int PW  = 37
) (
  input  logic [MW-1:0] perf,
  input  logic [IW-1:0] ipc_lo,
  input  logic [IW-1:0] ipc_hi,
  input  logic [CW-1:0] cmax,
  output logic [PW-1:0] scaled,
  output logic [PW-1:0] floor_tp,
  output logic [PW-1:0] peak_tp,
  output logic          above_floor,
  output logic          above_peak
);
  localparam int MQW = MW + QF;

  logic [MQW-1:0] perf_shift;

  always_comb begin
    perf_shift  = {perf, {QF{1'b0}}};
    scaled      = PW'(perf_shift);
    floor_tp    = PW'(ipc_lo) * PW'(cmax);
    peak_tp     = PW'(ipc_hi) * PW'(cmax);
    above_floor = scaled > floor_tp;
    above_peak  = scaled > peak_tp;
  end

endmodule

// File: rtl/gear_divider.sv
// Radix-2 restoring divider: one quotient bit per cycle, MSB first.
module gear_divider #(
  parameter int DVW = 53,
  parameter int DSW = 37
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [DVW-1:0] dividend,
  input  logic [DSW-1:0] divisor,
  output logic           fin,
  output logic [DVW-1:0] quot,
  output logic           rem_nz
);
  localparam int CNTW = $clog2(DVW + 1);

  logic [DSW-1:0]  rem_q;
  logic [DSW-1:0]  dvs_q;
  logic [DVW-1:0]  quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic [DSW:0]    partial;
  logic [DSW:0]    trial;

  always_comb begin
    partial = {rem_q, quo_q[DVW-1]};
    trial   = partial - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem_q <= '0;
        dvs_q <= divisor;
        quo_q <= dividend;
        cnt_q <= CNTW'(DVW);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[DSW]) begin
          rem_q <= trial[DSW-1:0];
          quo_q <= {quo_q[DVW-2:0], 1'b1};
        end else begin
          rem_q <= partial[DSW-1:0];
          quo_q <= {quo_q[DVW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quot   = quo_q;
  assign rem_nz = |rem_q;

endmodule

// File: rtl/gear_result.sv
// Rounds the quotient upward and maps it onto clock or gear by regime.
module gear_result #(
  parameter int DVW = 53,
  parameter int CW  = 24,
  parameter int GW  = 16
) (
  input  logic           regime_hi,
  input  logic [DVW-1:0] quot,
  input  logic           rem_nz,
  input  logic [CW-1:0]  cmax,
  output logic [CW-1:0]  clk_val,
  output logic [GW-1:0]  gear_val
);
  logic [DVW:0] rounded;
  logic         gear_ovf;

  always_comb begin
    rounded  = {1'b0, quot} + {{DVW{1'b0}}, rem_nz};
    gear_ovf = |rounded[DVW:GW];
    if (regime_hi) begin
      clk_val  = cmax;
      gear_val = gear_ovf ? {GW{1'b1}} : rounded[GW-1:0];
    end else begin
      clk_val  = rounded[CW-1:0];
      gear_val = '0;
    end
  end

endmodule

// File: rtl/gear_setpoint_ctrl.sv
module gear_setpoint_ctrl
  import gear_pkg::*;
#(
  parameter int MW = 32,
  parameter int IW = 8,
  parameter int CW = 24,
  parameter int QF = 4,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [MW-1:0] perf_req,
  input  logic [IW-1:0] ipc_lo,
  input  logic [IW-1:0] ipc_hi,
  input  logic [CW-1:0] clk_max,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] clk_set,
  output logic [GW-1:0] gear,
  output logic          sat
);
  localparam int MQW = MW + QF;
  localparam int PRW = IW + CW;
  localparam int PW  = max_of(MQW, PRW) + 1;
  localparam int DVW = PW + GW;
  localparam int DSW = PW;

  ctrl_state_t   state_q;
  logic [MW-1:0] perf_q;
  logic [IW-1:0] lo_q;
  logic [IW-1:0] hi_q;
  logic [CW-1:0] cmax_q;
  logic          regime_q;

  logic [PW-1:0]  scaled;
  logic [PW-1:0]  floor_tp;
  logic [PW-1:0]  peak_tp;
  logic           above_floor;
  logic           above_peak;
  logic           div_start;
  logic [DVW-1:0] div_dvd;
  logic [DSW-1:0] div_dvs;
  logic           div_fin;
  logic [DVW-1:0] div_quot;
  logic           div_rem_nz;
  logic [CW-1:0]  res_clk;
  logic [GW-1:0]  res_gear;
  logic [PW-1:0]  excess;

  gear_classify #(
    .MW(MW), .IW(IW), .CW(CW), .QF(QF), .PW(PW)
  ) u_classify (
    .perf       (perf_q),
    .ipc_lo     (lo_q),
    .ipc_hi     (hi_q),
    .cmax       (cmax_q),
    .scaled     (scaled),
    .floor_tp   (floor_tp),
    .peak_tp    (peak_tp),
    .above_floor(above_floor),
    .above_peak (above_peak)
  );

  always_comb begin
    excess    = scaled - floor_tp;
    div_start = (state_q == ST_SETUP) && !above_peak;
    if (above_floor) begin
      div_dvd = {excess, {GW{1'b0}}};
      div_dvs = peak_tp - floor_tp;
    end else begin
      div_dvd = DVW'(scaled);
      div_dvs = DSW'(lo_q);
    end
  end

  gear_divider #(
    .DVW(DVW), .DSW(DSW)
  ) u_divider (
    .clk     (clk),
    .rst     (rst),
    .start   (div_start),
    .dividend(div_dvd),
    .divisor (div_dvs),
    .fin     (div_fin),
    .quot    (div_quot),
    .rem_nz  (div_rem_nz)
  );

  gear_result #(
    .DVW(DVW), .CW(CW), .GW(GW)
  ) u_result (
    .regime_hi(regime_q),
    .quot     (div_quot),
    .rem_nz   (div_rem_nz),
    .cmax     (cmax_q),
    .clk_val  (res_clk),
    .gear_val (res_gear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      perf_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      cmax_q   <= '0;
      regime_q <= 1'b0;
      done     <= 1'b0;
      clk_set  <= '0;
      gear     <= '0;
      sat      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req) begin
            perf_q  <= perf_req;
            lo_q    <= ipc_lo;
            hi_q    <= ipc_hi;
            cmax_q  <= clk_max;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (above_peak) begin
            clk_set <= cmax_q;
            gear    <= {GW{1'b1}};
            sat     <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            regime_q <= above_floor;
            state_q  <= ST_DIVIDE;
          end
        end
        ST_DIVIDE: begin
          if (div_fin) begin
            clk_set <= res_clk;
            gear    <= res_gear;
            sat     <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/gear_setpoint_chk.sv
module gear_setpoint_chk #(
  parameter int CW = 24,
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] clk_set,
  input logic [GW-1:0] gear,
  input logic          sat
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(clk_set) && $stable(gear) && $stable(sat)));

  // R6
  sat_gear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && sat) |-> (gear == {GW{1'b1}}));

endmodule

bind gear_setpoint_ctrl gear_setpoint_chk #(.CW(CW), .GW(GW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .busy   (busy),
  .done   (done),
  .clk_set(clk_set),
  .gear   (gear),
  .sat    (sat)
);

// File: tb/gear_setpoint_ctrl_tb.sv
`timescale 1ns/1ps
module gear_setpoint_ctrl_tb;
  localparam int DIV_LAT = 56;
  localparam int SAT_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [31:0] perf_req = '0;
  logic [7:0]  ipc_lo = '0;
  logic [7:0]  ipc_hi = '0;
  logic [23:0] clk_max = '0;
  logic        busy, done, sat;
  logic [23:0] clk_set;
  logic [15:0] gear;

  int checks = 0;
  int errors = 0;
  longint cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  gear_setpoint_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .perf_req(perf_req),
    .ipc_lo(ipc_lo), .ipc_hi(ipc_hi), .clk_max(clk_max),
    .busy(busy), .done(done), .clk_set(clk_set), .gear(gear), .sat(sat)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned m, lo, hi, cm,
                                output longint unsigned ec, eg, output bit es);
    longint unsigned mq, f, p, g;
    mq = m * 16; f = lo * cm; p = hi * cm;
    es = 1'b0;
    if (mq > p) begin
      es = 1'b1; ec = cm; eg = 65535;
    end else if (mq <= f) begin
      ec = (mq + lo - 1) / lo; eg = 0;
    end else begin
      ec = cm;
      g = (((mq - f) << 16) + (p - f) - 1) / (p - f);
      eg = (g > 65535) ? 65535 : g;
    end
  endfunction

  // Issues one request, waits for done, checks latency, results and pulse width.
  task automatic run_case(input string tag, input longint unsigned m, lo, hi, cm);
    longint unsigned ec, eg;
    bit es;
    int lat;
    model(m, lo, hi, cm, ec, eg, es);
    @(negedge clk);
    perf_req = m[31:0]; ipc_lo = lo[7:0]; ipc_hi = hi[7:0]; clk_max = cm[23:0];
    req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      lat++;
    end while (!done && lat < 200);
    chk(lat == (es ? SAT_LAT : DIV_LAT), {tag, " R7 latency"}, lat, es ? SAT_LAT : DIV_LAT);
    chk(clk_set == ec, {tag, " clk_set"}, clk_set, ec);
    chk(gear == eg, {tag, " gear"}, gear, eg);
    chk(sat == es, {tag, " sat"}, sat, es);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 single done"}, done, 0);
  endtask

  task automatic t_reset;
    chk(clk_set == 0 && gear == 0 && sat == 0, "R1 outputs", {clk_set, gear, sat}, 0);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
  endtask

  task automatic t_clock_regime;
    run_case("R2 exact", 500, 16, 64, 1000);
    run_case("R2 roundup", 100, 24, 64, 1000);
    run_case("R2 zero", 0, 16, 64, 1000);
  endtask

  task automatic t_boundary;
    run_case("R3 floor", 1000, 16, 64, 1000);
  endtask

  task automatic t_gear_regime;
    run_case("R4 just above", 1001, 16, 64, 1000);
    run_case("R4 mid", 2500, 16, 64, 1000);
  endtask

  task automatic t_peak;
    run_case("R5 peak", 4000, 16, 64, 1000);
  endtask

  task automatic t_saturate;
    run_case("R6 over", 4001, 16, 64, 1000);
    run_case("R6 flat", 1001, 16, 16, 1000);
  endtask

  // Request held high through the whole busy window, including the finishing edge.
  task automatic t_ignore;
    longint unsigned ec, eg;
    bit es;
    int n;
    model(2500, 16, 64, 1000, ec, eg, es);
    @(negedge clk);
    perf_req = 2500; ipc_lo = 16; ipc_hi = 64; clk_max = 1000;
    req = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    perf_req = 500;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    chk(gear == eg && clk_set == ec, "R8 first result kept", gear, eg);
    @(negedge clk);
    chk(!done && !busy, "R8 no second done", {done, busy}, 0);
    repeat (60) @(negedge clk);
    chk(gear == eg && clk_set == ec, "R8 late ignore", gear, eg);
  endtask

  task automatic t_hold;
    logic [23:0] c0;
    logic [15:0] g0;
    c0 = clk_set; g0 = gear;
    @(negedge clk);
    perf_req = 7; ipc_lo = 40; ipc_hi = 50; clk_max = 3;
    repeat (20) @(negedge clk);
    chk(clk_set == c0 && gear == g0 && !sat, "R9 hold without req", gear, g0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_clock_regime;
    t_boundary;
    t_gear_regime;
    t_peak;
    t_saturate;
    t_ignore;
    t_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule